// File: doc/BRIEF.md
# Self-timed byte-write controller for a parallel nonvolatile array

This block sits in front of a byte-wide nonvolatile array that the host reaches like a static RAM through three active-low strobes: chip select, output enable and write strobe. A write pulse hands over one byte. The block holds the target address and value internally. It then runs a timed two-step internal cycle on its own: first the target byte is erased to all ones, then the held value is programmed. The host can use the bus for other work while this happens. It learns that the cycle has finished either from a busy line or by reading back and watching the top data bit, which comes back inverted until the cycle is over.

Two qualifier inputs stand in for high-voltage pin levels. With one of them set during a write pulse, the block runs a timed clear of the whole main array. With the other set, reads and writes go to a small separate identification row. All strobes and qualifiers pass through two-stage synchronizers, and the block acts on edges of the synchronized copies. The array is a register file in the default build, 1K x 8 plus a 32-byte identification row. Durations are counted in clock cycles.

Top module: `eeprom_wctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `busy_pull`, `dout_en` and `dout` are 0 after that edge. No array byte changes during or because of the reset.
- R2: `dout_en` is 1 exactly when `ce_n` and `oe_n` were both low three clock edges earlier. When `dout_en` is 0, `dout` is 8'h00. When idle, `dout` is the byte at `addr`.
- R3: A write pulse is the time when `ce_n` and `we_n` are both low. It starts with whichever strobe falls last and ends with whichever rises first. If the block is idle when the end of the pulse reaches the synchronizer output, and `oe_n` is high with `oe_hv` low, it captures `addr`, `din` and `a9_hv` in that cycle. These inputs must be held for at least three clocks after the pulse ends.
- R4: `busy_pull` rises on the third clock edge after the edge that first samples the ended pulse. It stays high for exactly WR_CYC clocks for a byte write and CLR_CYC clocks for a clear.
- R5: A byte write first erases the target byte to 8'hFF after WR_CYC/2 busy clocks, then stores the captured value at the end. A reset in the erase half leaves the old byte. A reset in the program half leaves 8'hFF.
- R6: While busy, every enabled read returns the captured value with bit 7 inverted. Once idle, reads return the stored data.
- R7: A write pulse that ends while the block is busy is ignored. It neither changes the array nor lengthens the busy time.
- R8: A write pulse that ends with `oe_n` low and `oe_hv` low is ignored.
- R9: A write pulse that ends with `oe_hv` high starts a clear. For its whole duration, reads return 8'h7F. At its end every main byte is 8'hFF, and the identification row is unchanged.
- R10: With `a9_hv` high, reads and writes use the 32-byte identification row, indexed by `addr[4:0]`. The main array is not touched.
- R11: Parameter FAST_WRITE=1 selects WR_CYC=FAST_CYC (default 40), and 0 selects STD_CYC (default 200).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_hv | input | 1 | Output-enable pin at high voltage (clear qualifier) |
| a9_hv | input | 1 | Address pin at high voltage (identification-row qualifier) |
| addr | input | AW | Byte address |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |
| busy_pull | output | 1 | Open-drain pull-down enable, 1 while busy |

## Verification
A sequencer stuck in a wrong phase shows at once on `busy_pull`, since its length and start edge are fixed to the clock. A wrong captured byte shows on the very next enabled read through the inverted bit 7. An erase or program step fired at the wrong time only shows in the stored data. To catch that, the bench resets in the middle of each half of the cycle and reads the byte back a few clocks later. A mistake in strobe gating shows on `dout_en` three clocks after the strobes change, and the reference model compares every clock against it.

// File: rtl/eewc_pkg.sv
package eewc_pkg;
    typedef enum logic [1:0] {
        MD_IDLE  = 2'd0,
        MD_ERASE = 2'd1,
        MD_PROG  = 2'd2,
        MD_CLEAR = 2'd3
    } mode_e;

    // bit positions inside the synchronized control vector
    localparam int CTL_W   = 5;
    localparam int CI_CE   = 0;
    localparam int CI_WE   = 1;
    localparam int CI_OE   = 2;
    localparam int CI_OEHV = 3;
    localparam int CI_A9HV = 4;
    localparam logic [CTL_W-1:0] CTL_IDLE = 5'b00111;
endpackage

// File: rtl/eewc_sync.sv
module eewc_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[i] <= RST_VAL;
                    else        stg_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[i] <= RST_VAL;
                    else        stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/eewc_store.sv
module eewc_store #(
    parameter int AW   = 10,
    parameter int DW   = 8,
    parameter int SIGW = 5
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_sig,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          clr_all,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_sig,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH  = 1 << AW;
    localparam int SDEPTH = 1 << SIGW;

    logic [DW-1:0] main_q [DEPTH];
    logic [DW-1:0] sig_q  [SDEPTH];

    always_ff @(posedge clk) begin
        if (clr_all) begin
            for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
        end else if (wr_en && !wr_sig) begin
            main_q[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_sig) sig_q[wr_addr[SIGW-1:0]] <= wr_data;
    end

    assign rd_data = rd_sig ? sig_q[rd_addr[SIGW-1:0]] : main_q[rd_addr];
endmodule

// File: rtl/eewc_seq.sv
module eewc_seq
    import eewc_pkg::*;
#(
    parameter int AW      = 10,
    parameter int DW      = 8,
    parameter int WR_CYC  = 40,
    parameter int CLR_CYC = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          we_s,
    input  logic          oe_s,
    input  logic          oehv_s,
    input  logic          a9_s,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic          wr_sig,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          clr_all,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          busy
);
    localparam int ERASE_CYC = WR_CYC / 2;
    localparam int PROG_CYC  = WR_CYC - ERASE_CYC;
    localparam int MAX_CYC   = (CLR_CYC > WR_CYC) ? CLR_CYC : WR_CYC;
    localparam int CW        = $clog2(MAX_CYC + 1);

    typedef struct packed {
        mode_e         mode;
        logic [CW-1:0] cnt;
        logic [AW-1:0] la;
        logic [DW-1:0] ld;
        logic          ls;
        logic          ws;
        logic [DW-1:0] dout;
        logic          den;
    } st_t;

    st_t  st_q, st_d;
    logic pulse_on;
    logic pulse_end;

    always_comb begin
        st_d      = st_q;
        pulse_on  = !ce_s && !we_s;
        pulse_end = st_q.ws && !pulse_on;
        st_d.ws   = pulse_on;

        // read path: poll value while busy, array data when idle
        st_d.den  = !ce_s && !oe_s;
        st_d.dout = '0;
        if (st_d.den) begin
            if (st_q.mode != MD_IDLE) st_d.dout = {~st_q.ld[DW-1], st_q.ld[DW-2:0]};
            else                      st_d.dout = rd_data;
        end

        wr_en   = 1'b0;
        wr_data = st_q.ld;
        clr_all = 1'b0;

        unique case (st_q.mode)
            MD_IDLE: begin
                if (pulse_end) begin
                    if (oehv_s) begin
                        st_d.mode = MD_CLEAR;
                        st_d.cnt  = CW'(CLR_CYC - 1);
                        st_d.ld   = '1;
                    end else if (oe_s) begin
                        st_d.mode = MD_ERASE;
                        st_d.cnt  = CW'(ERASE_CYC - 1);
                        st_d.la   = addr;
                        st_d.ld   = din;
                        st_d.ls   = a9_s;
                    end
                end
            end
            MD_ERASE: begin
                if (st_q.cnt == '0) begin
                    wr_en     = rst_n;
                    wr_data   = '1;
                    st_d.mode = MD_PROG;
                    st_d.cnt  = CW'(PROG_CYC - 1);
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            MD_PROG: begin
                if (st_q.cnt == '0) begin
                    wr_en     = rst_n;
                    st_d.mode = MD_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            MD_CLEAR: begin
                if (st_q.cnt == '0) begin
                    clr_all   = rst_n;
                    st_d.mode = MD_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            default: st_d.mode = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_t'('0);
        else        st_q <= st_d;
    end

    assign wr_sig  = st_q.ls;
    assign wr_addr = st_q.la;
    assign dout    = st_q.dout;
    assign dout_en = st_q.den;
    assign busy    = (st_q.mode != MD_IDLE);
endmodule

// File: rtl/eeprom_wctl.sv
module eeprom_wctl
    import eewc_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 8,
    parameter int SIGW       = 5,
    parameter bit FAST_WRITE = 1'b1,
    parameter int FAST_CYC   = 40,
    parameter int STD_CYC    = 200,
    parameter int CLR_CYC    = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          oe_hv,
    input  logic          a9_hv,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          busy_pull
);
    localparam int WR_CYC = FAST_WRITE ? FAST_CYC : STD_CYC;

    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic             st_wr_en, st_wr_sig, st_clr;
    logic [AW-1:0]    st_wr_addr;
    logic [DW-1:0]    st_wr_data, st_rd_data;

    assign ctl_raw[CI_CE]   = ce_n;
    assign ctl_raw[CI_WE]   = we_n;
    assign ctl_raw[CI_OE]   = oe_n;
    assign ctl_raw[CI_OEHV] = oe_hv;
    assign ctl_raw[CI_A9HV] = a9_hv;

    eewc_sync #(.W(CTL_W), .STAGES(2), .RST_VAL(CTL_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    eewc_seq #(.AW(AW), .DW(DW), .WR_CYC(WR_CYC), .CLR_CYC(CLR_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ctl_s[CI_CE]),
        .we_s    (ctl_s[CI_WE]),
        .oe_s    (ctl_s[CI_OE]),
        .oehv_s  (ctl_s[CI_OEHV]),
        .a9_s    (ctl_s[CI_A9HV]),
        .addr    (addr),
        .din     (din),
        .rd_data (st_rd_data),
        .wr_en   (st_wr_en),
        .wr_sig  (st_wr_sig),
        .wr_addr (st_wr_addr),
        .wr_data (st_wr_data),
        .clr_all (st_clr),
        .dout    (dout),
        .dout_en (dout_en),
        .busy    (busy_pull)
    );

    eewc_store #(.AW(AW), .DW(DW), .SIGW(SIGW)) u_store (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_sig  (st_wr_sig),
        .wr_addr (st_wr_addr),
        .wr_data (st_wr_data),
        .clr_all (st_clr),
        .rd_addr (addr),
        .rd_sig  (ctl_s[CI_A9HV]),
        .rd_data (st_rd_data)
    );
endmodule

// File: rtl/eeprom_wctl_chk.sv
module eeprom_wctl_chk #(
    parameter int DW      = 8,
    parameter int WR_CYC  = 40,
    parameter int CLR_CYC = 100
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          dout_en,
    input logic          busy_pull,
    input logic [DW-1:0] dout,
    input logic          wr_en,
    input logic          clr_all
);
    localparam int MAX_BUSY = (CLR_CYC > WR_CYC) ? CLR_CYC : WR_CYC;
    localparam int RW       = $clog2(MAX_BUSY + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (busy_pull) run_q <= run_q + RW'(1);
        else                run_q <= '0;
    end

    // busy never outlasts the longest timed cycle
    p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull |-> (run_q < RW'(MAX_BUSY)));

    // array changes only inside a timed cycle
    p_array_in_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || clr_all) |-> busy_pull);

    // a byte update and a full clear never coincide
    p_single_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, clr_all}));

    // driver enabled only after both strobes were low three edges back
    p_read_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!$past(ce_n, 3) && !$past(oe_n, 3)));

    // undriven bus reads as zero
    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));
endmodule

bind eeprom_wctl eeprom_wctl_chk #(.DW(DW), .WR_CYC(WR_CYC), .CLR_CYC(CLR_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .dout_en   (dout_en),
    .busy_pull (busy_pull),
    .dout      (dout),
    .wr_en     (st_wr_en),
    .clr_all   (st_clr)
);

// File: tb/eeprom_wctl_test.sv
module eeprom_wctl_test;
    localparam int ERASE_N = 20;   // R11: fast variant, 40 clocks split in halves
    localparam int PROG_N  = 20;
    localparam int CLEAR_N = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
    logic [9:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en, busy_pull;

    int checks = 0;
    int fails  = 0;

    always #5ns clk = ~clk;

    eeprom_wctl uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .busy_pull(busy_pull)
    );

    // ---------------- reference model, stepped once per clock ----------------
    int  mm [1024];
    int  sg [32];
    int  m_mode = 0, m_rem = 0, m_la = 0, m_ld = 0, m_ls = 0, m_wsp = 0;
    int  p1c = 1, p1w = 1, p1o = 1, p1h = 0, p1a = 0;
    int  p2c = 1, p2w = 1, p2o = 1, p2h = 0, p2a = 0;
    int  e_den = 0, e_dout = 0, e_poll = 0;
    bit  live = 1'b0;

    initial begin
        for (int i = 0; i < 1024; i++) mm[i] = -1;
        for (int i = 0; i < 32; i++)   sg[i] = -1;
    end

    always @(negedge clk) begin : mdl
        int ws;
        int rv;
        if (!rst_n) begin
            m_mode = 0; m_rem = 0; m_wsp = 0;
            p1c = 1; p1w = 1; p1o = 1; p1h = 0; p1a = 0;
            p2c = 1; p2w = 1; p2o = 1; p2h = 0; p2a = 0;
            e_den = 0; e_dout = 0; e_poll = 0;
            live = 1'b1;
        end else if (live) begin
            ws     = (p2c == 0 && p2w == 0) ? 1 : 0;
            rv     = (p2a != 0) ? sg[addr[4:0]] : mm[addr];
            e_den  = (p2c == 0 && p2o == 0) ? 1 : 0;
            e_poll = (m_mode != 0) ? 1 : 0;
            if (e_den == 0)       e_dout = 0;
            else if (m_mode != 0) e_dout = m_ld ^ 'h80;
            else                  e_dout = rv;
            case (m_mode)
                0: if (ws == 0 && m_wsp == 1) begin
                       if (p2h != 0) begin
                           m_mode = 3; m_rem = CLEAR_N - 1; m_ld = 'hFF;
                       end else if (p2o != 0) begin
                           m_mode = 1; m_rem = ERASE_N - 1;
                           m_la = int'(addr); m_ld = int'(din); m_ls = p2a;
                       end
                   end
                1: if (m_rem == 0) begin
                       if (m_ls != 0) sg[m_la % 32] = 'hFF; else mm[m_la] = 'hFF;
                       m_mode = 2; m_rem = PROG_N - 1;
                   end else m_rem--;
                2: if (m_rem == 0) begin
                       if (m_ls != 0) sg[m_la % 32] = m_ld; else mm[m_la] = m_ld;
                       m_mode = 0;
                   end else m_rem--;
                default: if (m_rem == 0) begin
                       for (int i = 0; i < 1024; i++) mm[i] = 'hFF;
                       m_mode = 0;
                   end else m_rem--;
            endcase
            m_wsp = ws;
            p2c = p1c; p2w = p1w; p2o = p1o; p2h = p1h; p2a = p1a;
            p1c = ce_n; p1w = we_n; p1o = oe_n; p1h = oe_hv; p1a = a9_hv;
        end
        if (live) begin
            checks++;
            if (busy_pull !== (m_mode != 0)) begin
                fails++;
                $display("FAIL R4 R11 busy_pull act=%0b exp=%0b t=%0t", busy_pull, (m_mode != 0), $time);
            end
            if (dout_en !== e_den[0]) begin
                fails++;
                $display("FAIL R2 dout_en act=%0b exp=%0b t=%0t", dout_en, e_den[0], $time);
            end
            if (e_dout >= 0 && dout !== e_dout[7:0]) begin
                fails++;
                if (e_poll != 0) $display("FAIL R6 poll dout act=%02h exp=%02h t=%0t", dout, e_dout[7:0], $time);
                else             $display("FAIL R2 dout act=%02h exp=%02h t=%0t", dout, e_dout[7:0], $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1ns;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int a, input int d, input bit sig, input bit oe_low, input bit hv);
        addr = 10'(a); din = 8'(d); a9_hv = sig; oe_hv = hv; oe_n = oe_low ? 1'b0 : 1'b1;
        ce_n = 1'b0; tick(1);
        we_n = 1'b0; tick(3);
        we_n = 1'b1; tick(1);
        ce_n = 1'b1; tick(4);
        a9_hv = 1'b0; oe_hv = 1'b0; oe_n = 1'b1;
        tick(1);
    endtask

    task automatic rd(input int a, input bit sig, input int exp, input string req);
        addr = 10'(a); a9_hv = sig; ce_n = 1'b0; oe_n = 1'b0;
        tick(4);
        chk(dout_en === 1'b1 && dout === 8'(exp), req, int'(dout), exp);
        ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0;
        tick(4);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy_pull; i++) tick(1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(2);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk(busy_pull === 1'b0 && dout_en === 1'b0 && dout === 8'h00, "R1 reset outputs",
            int'({busy_pull, dout_en, dout}), 0);

        // R9: full clear, poll reads 7F while running
        pulse(0, 0, 1'b0, 1'b0, 1'b1);
        chk(busy_pull === 1'b1, "R9 clear busy", int'(busy_pull), 1);
        rd(12, 1'b0, 'h7F, "R9 clear poll");
        wait_idle();
        rd(5, 1'b0, 'hFF, "R9 cleared byte");
        rd(1023, 1'b0, 'hFF, "R9 cleared top byte");

        // R3 R6: write then poll then true data
        pulse(5, 'h3C, 1'b0, 1'b0, 1'b0);
        rd(5, 1'b0, 'hBC, "R6 poll inverted bit7");
        wait_idle();
        rd(5, 1'b0, 'h3C, "R3 stored byte");

        // R7: write during busy is ignored; boundary address
        pulse(1023, 'hA5, 1'b0, 1'b0, 1'b0);
        pulse(7, 'h11, 1'b0, 1'b0, 1'b0);
        wait_idle();
        rd(7, 1'b0, 'hFF, "R7 ignored write");
        rd(1023, 1'b0, 'hA5, "R3 top address");

        // R8: write with output enable low is ignored
        pulse(9, 'h22, 1'b0, 1'b1, 1'b0);
        chk(busy_pull === 1'b0, "R8 no busy", int'(busy_pull), 0);
        rd(9, 1'b0, 'hFF, "R8 byte unchanged");

        // R10: identification row
        pulse(3, 'h5A, 1'b1, 1'b0, 1'b0);
        wait_idle();
        rd(3, 1'b1, 'h5A, "R10 id row byte");
        rd(3, 1'b0, 'hFF, "R10 main untouched");

        // R5: reset in program half leaves erased byte
        pulse(20, 'h12, 1'b0, 1'b0, 1'b0);
        tick(20);
        do_reset();
        chk(busy_pull === 1'b0, "R1 reset aborts", int'(busy_pull), 0);
        rd(20, 1'b0, 'hFF, "R5 erased before program");

        // R5: reset in erase half keeps the old byte
        pulse(21, 'h56, 1'b0, 1'b0, 1'b0);
        wait_idle();
        pulse(21, 'h34, 1'b0, 1'b0, 1'b0);
        tick(2);
        do_reset();
        rd(21, 1'b0, 'h56, "R5 old byte kept");

        // R9: second clear spares the id row
        pulse(0, 0, 1'b0, 1'b0, 1'b1);
        wait_idle();
        rd(5, 1'b0, 'hFF, "R9 main cleared");
        rd(3, 1'b1, 'h5A, "R9 id row kept");

        tick(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule